// File: doc/BRIEF.md
# Infrared UART Interrupt Identification

This block gathers the eight interrupt conditions of a UART that can run an infrared link, either as framed IrDA traffic or as raw consumer-IR (CIR) pulses. It shows them as an eight-bit identification word with one bit per source, and it drives one interrupt line that is the OR of every enabled bit. No priority encoding is applied. Each source keeps its own set condition and its own clear rule. Some bits follow a live level from the data path. Some are sticky flags that clear on a particular register access. One flag clears only when the status FIFO is drained.

The surrounding register file passes in single-cycle strobes for the register accesses that matter: a receive holding register read, an identification read, a resume read and a status FIFO read. The data path supplies condition levels and single-cycle events. A mode input selects the IrDA or the CIR meaning of the bits. A per-bit mask hides bits from both the identification word and the interrupt line. A separate output records that the transmit-status bit was raised by an underrun and not by a clean completion.

Top module: `ir_uart_irq_ident`

## Requirements
- R1: Bit 0 is combinational. When `fifo_en` is 0 it equals `rx_data_ready`; when `fifo_en` is 1 it equals `rx_above_trig`.
- R2: Bit 1 is combinational. When `fifo_en` is 0 it equals `tx_hold_empty`; when `fifo_en` is 1 it equals `tx_below_trig`.
- R3: In IrDA mode (`cir_mode`=0), bit 2 sets one cycle after `ev_rx_last_byte`. It clears one cycle after `acc_rhr_rd`. An identification read leaves it unchanged.
- R4: Bit 3 sets one cycle after `ev_rx_overrun` and clears only one cycle after `acc_resume_rd`.
- R5: Bit 4 follows `stat_at_trig` combinationally in IrDA mode.
- R6: In IrDA mode, bit 5 is the OR of two flags. The underrun flag sets on `ev_tx_underrun`, clears on `acc_resume_rd`, and is also visible on `tx_underrun_flag`. The completion flag sets on `ev_tx_done` and clears on `acc_iir_rd`.
- R7: In IrDA mode, bit 6 sets one cycle after `ev_stat_err_wr`. It clears one cycle after an `acc_stat_rd` made while `stat_level` is 1, because that read empties the status FIFO. A status read at a higher level leaves it set.
- R8: In IrDA mode, bit 7 sets one cycle after `ev_rx_eof` and clears one cycle after `acc_iir_rd`.
- R9: In CIR mode (`cir_mode`=1), bits 4, 6 and 7 read 0. Bit 2 sets on `ev_cir_rx_stop` and clears on `acc_iir_rd` only; `ev_rx_last_byte` does not set it. Bit 5 shows only the completion flag, and `ev_tx_underrun` is ignored.
- R10: During an identification read, the word presented in that cycle still shows bits that the read clears. When a set event and its clearing access fall in the same cycle, the bit stays set.
- R11: `iir_value` equals the raw bits ANDed with `irq_mask`, and `irq_out` is 1 exactly when `iir_value` is nonzero.
- R12: While `rst_n` is low, all sticky flags and `tx_underrun_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cir_mode | input | 1 | 0 selects IrDA meanings, 1 selects CIR meanings |
| fifo_en | input | 1 | Selects FIFO trigger conditions for bits 0 and 1 |
| irq_mask | input | 8 | Per-bit enable |
| rx_data_ready | input | 1 | Receive holding register has data (level) |
| rx_above_trig | input | 1 | RX FIFO is above its trigger level (level) |
| tx_hold_empty | input | 1 | Transmit holding register is empty (level) |
| tx_below_trig | input | 1 | TX FIFO is below its trigger level (level) |
| stat_at_trig | input | 1 | Status FIFO has reached its trigger level (level) |
| stat_level | input | LVL_W | Current status FIFO occupancy |
| ev_rx_last_byte | input | 1 | Last byte of a frame has reached the RX holding register |
| ev_rx_overrun | input | 1 | Write attempted into a full RX FIFO |
| ev_tx_underrun | input | 1 | Transmit holding register ran empty before end-of-frame |
| ev_tx_done | input | 1 | Last bit of a frame has left the transmitter |
| ev_stat_err_wr | input | 1 | CRC, abort or length error written to the status FIFO |
| ev_rx_eof | input | 1 | End-of-frame received |
| ev_cir_rx_stop | input | 1 | CIR receive stop detected |
| acc_rhr_rd | input | 1 | Receive holding register read strobe |
| acc_iir_rd | input | 1 | Identification register read strobe |
| acc_resume_rd | input | 1 | Resume register read strobe |
| acc_stat_rd | input | 1 | Status FIFO read strobe |
| iir_value | output | 8 | Masked identification word |
| irq_out | output | 1 | Interrupt request |
| tx_underrun_flag | output | 1 | Transmit-status bit was caused by an underrun |

## Verification
Every sticky flag reaches `iir_value` through the mask only, with no register in between. A flag that is stuck, cleared by the wrong access or never set therefore shows up on the identification word, and on `irq_out`, in the cycle after the triggering event or access. The bench looks for exactly that. After each event and each access it reads the word one cycle later, and it also tries accesses that must not clear a bit. Mode remapping and mask gating are swept over every mask value and every combination of level inputs, so a mux or gating fault shows up in the same cycle.

// File: rtl/ir_irq_pkg.sv
package ir_irq_pkg;
   localparam int unsigned IIR_W    = 8;
   localparam int unsigned B_RXDATA = 0;
   localparam int unsigned B_TXROOM = 1;
   localparam int unsigned B_FRMB   = 2;
   localparam int unsigned B_OVR    = 3;
   localparam int unsigned B_STRIG  = 4;
   localparam int unsigned B_TXSTAT = 5;
   localparam int unsigned B_LSR    = 6;
   localparam int unsigned B_EOF    = 7;
endpackage

// File: rtl/ir_irq_sticky.sv
module ir_irq_sticky #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   logic nxt;

   generate
      if (SET_WINS) begin : g_set_prio
         assign nxt = set_i | (flag_o & ~clr_i);
      end else begin : g_clr_prio
         assign nxt = ~clr_i & (set_i | flag_o);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_o <= 1'b0;
      else        flag_o <= nxt;
   end
endmodule

// File: rtl/ir_irq_level_src.sv
module ir_irq_level_src (
   input  logic fifo_en,
   input  logic direct_i,
   input  logic fifo_i,
   output logic lvl_o
);
   always_comb begin
      lvl_o = fifo_en ? fifo_i : direct_i;
   end
endmodule

// File: rtl/ir_irq_stat_err.sv
module ir_irq_stat_err #(
   parameter int unsigned STAT_DEPTH = 8,
   parameter int unsigned LVL_W      = $clog2(STAT_DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable_i,
   input  logic             err_wr_i,
   input  logic             stat_rd_i,
   input  logic [LVL_W-1:0] level_i,
   output logic             flag_o
);
   localparam logic [LVL_W-1:0] LAST_ONE = LVL_W'(1);

   logic drains;
   logic set_c;

   assign drains = stat_rd_i && (level_i == LAST_ONE);
   assign set_c  = enable_i & err_wr_i;

   ir_irq_sticky #(.SET_WINS(1'b1)) i_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_c),
      .clr_i  (drains),
      .flag_o (flag_o)
   );
endmodule

// File: rtl/ir_uart_irq_ident.sv
module ir_uart_irq_ident
   import ir_irq_pkg::*;
#(
   parameter int unsigned STAT_DEPTH = 8,
   parameter bit          SET_WINS   = 1'b1,
   localparam int unsigned LVL_W     = $clog2(STAT_DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cir_mode,
   input  logic             fifo_en,
   input  logic [7:0]       irq_mask,
   input  logic             rx_data_ready,
   input  logic             rx_above_trig,
   input  logic             tx_hold_empty,
   input  logic             tx_below_trig,
   input  logic             stat_at_trig,
   input  logic [LVL_W-1:0] stat_level,
   input  logic             ev_rx_last_byte,
   input  logic             ev_rx_overrun,
   input  logic             ev_tx_underrun,
   input  logic             ev_tx_done,
   input  logic             ev_stat_err_wr,
   input  logic             ev_rx_eof,
   input  logic             ev_cir_rx_stop,
   input  logic             acc_rhr_rd,
   input  logic             acc_iir_rd,
   input  logic             acc_resume_rd,
   input  logic             acc_stat_rd,
   output logic [7:0]       iir_value,
   output logic             irq_out,
   output logic             tx_underrun_flag
);
   generate
      if (STAT_DEPTH < 2) begin : g_bad_depth
         $error("STAT_DEPTH must be at least 2");
      end
      if (IIR_W != 8) begin : g_bad_width
         $error("identification word must be eight bits");
      end
   endgenerate

   logic irda;
   logic lvl_rx, lvl_tx;
   logic b2_set, b2_clr, b2_q;
   logic ovr_q, undr_q, txok_q, serr_q, eof_q;
   logic [IIR_W-1:0] raw;

   assign irda = ~cir_mode;

   ir_irq_level_src i_lvl_rx (
      .fifo_en  (fifo_en),
      .direct_i (rx_data_ready),
      .fifo_i   (rx_above_trig),
      .lvl_o    (lvl_rx)
   );

   ir_irq_level_src i_lvl_tx (
      .fifo_en  (fifo_en),
      .direct_i (tx_hold_empty),
      .fifo_i   (tx_below_trig),
      .lvl_o    (lvl_tx)
   );

   assign b2_set = cir_mode ? ev_cir_rx_stop : ev_rx_last_byte;
   assign b2_clr = cir_mode ? acc_iir_rd     : acc_rhr_rd;

   ir_irq_sticky #(.SET_WINS(SET_WINS)) i_frmb (
      .clk (clk), .rst_n (rst_n), .set_i (b2_set), .clr_i (b2_clr), .flag_o (b2_q)
   );

   ir_irq_sticky #(.SET_WINS(SET_WINS)) i_ovr (
      .clk (clk), .rst_n (rst_n), .set_i (ev_rx_overrun), .clr_i (acc_resume_rd), .flag_o (ovr_q)
   );

   ir_irq_sticky #(.SET_WINS(SET_WINS)) i_undr (
      .clk (clk), .rst_n (rst_n), .set_i (irda & ev_tx_underrun), .clr_i (acc_resume_rd),
      .flag_o (undr_q)
   );

   ir_irq_sticky #(.SET_WINS(SET_WINS)) i_txok (
      .clk (clk), .rst_n (rst_n), .set_i (ev_tx_done), .clr_i (acc_iir_rd), .flag_o (txok_q)
   );

   ir_irq_sticky #(.SET_WINS(SET_WINS)) i_eof (
      .clk (clk), .rst_n (rst_n), .set_i (irda & ev_rx_eof), .clr_i (acc_iir_rd), .flag_o (eof_q)
   );

   ir_irq_stat_err #(.STAT_DEPTH(STAT_DEPTH), .LVL_W(LVL_W)) i_serr (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable_i  (irda),
      .err_wr_i  (ev_stat_err_wr),
      .stat_rd_i (acc_stat_rd),
      .level_i   (stat_level),
      .flag_o    (serr_q)
   );

   always_comb begin
      raw           = '0;
      raw[B_RXDATA] = lvl_rx;
      raw[B_TXROOM] = lvl_tx;
      raw[B_FRMB]   = b2_q;
      raw[B_OVR]    = ovr_q;
      raw[B_STRIG]  = irda & stat_at_trig;
      raw[B_TXSTAT] = cir_mode ? txok_q : (txok_q | undr_q);
      raw[B_LSR]    = irda & serr_q;
      raw[B_EOF]    = irda & eof_q;
   end

   assign iir_value        = raw & irq_mask;
   assign irq_out          = |iir_value;
   assign tx_underrun_flag = undr_q;
endmodule

// File: rtl/ir_irq_checker.sv
module ir_irq_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       cir_mode,
   input logic       ev_rx_overrun,
   input logic       ev_tx_underrun,
   input logic       ev_tx_done,
   input logic       ev_rx_eof,
   input logic       acc_iir_rd,
   input logic       acc_resume_rd,
   input logic [7:0] iir_value,
   input logic       tx_underrun_flag,
   input logic       ovr_q,
   input logic       txok_q,
   input logic       eof_q
);
   AST_OVR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      ev_rx_overrun |=> ovr_q); // R4
   AST_OVR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_q && !acc_resume_rd) |=> ovr_q); // R4
   AST_UNDR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_underrun_flag && acc_resume_rd && !ev_tx_underrun) |=> !tx_underrun_flag); // R6
   AST_TXOK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      ev_tx_done |=> txok_q); // R6
   AST_EOF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (eof_q && acc_iir_rd && !ev_rx_eof) |=> !eof_q); // R8
   AST_EOF_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (!cir_mode && ev_rx_eof && acc_iir_rd) |=> eof_q); // R10
   AST_CIR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      cir_mode |-> (iir_value[7:6] == 2'b00 && !iir_value[4])); // R9
endmodule

bind ir_uart_irq_ident ir_irq_checker i_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .cir_mode         (cir_mode),
   .ev_rx_overrun    (ev_rx_overrun),
   .ev_tx_underrun   (ev_tx_underrun),
   .ev_tx_done       (ev_tx_done),
   .ev_rx_eof        (ev_rx_eof),
   .acc_iir_rd       (acc_iir_rd),
   .acc_resume_rd    (acc_resume_rd),
   .iir_value        (iir_value),
   .tx_underrun_flag (tx_underrun_flag),
   .ovr_q            (ovr_q),
   .txok_q           (txok_q),
   .eof_q            (eof_q)
);

// File: tb/test_ir_uart_irq_ident.sv
module test_ir_uart_irq_ident;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cir_mode = 0, fifo_en = 0;
   logic [7:0] irq_mask = 8'hFF;
   logic rx_data_ready = 0, rx_above_trig = 0, tx_hold_empty = 0, tx_below_trig = 0;
   logic stat_at_trig = 0;
   logic [3:0] stat_level = 0;
   logic ev_rx_last_byte = 0, ev_rx_overrun = 0, ev_tx_underrun = 0, ev_tx_done = 0;
   logic ev_stat_err_wr = 0, ev_rx_eof = 0, ev_cir_rx_stop = 0;
   logic acc_rhr_rd = 0, acc_iir_rd = 0, acc_resume_rd = 0, acc_stat_rd = 0;
   logic [7:0] iir_value;
   logic irq_out, tx_underrun_flag;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #4 clk = ~clk;

   ir_uart_irq_ident i_ir_uart_irq_ident (
      .clk(clk), .rst_n(rst_n), .cir_mode(cir_mode), .fifo_en(fifo_en), .irq_mask(irq_mask),
      .rx_data_ready(rx_data_ready), .rx_above_trig(rx_above_trig),
      .tx_hold_empty(tx_hold_empty), .tx_below_trig(tx_below_trig),
      .stat_at_trig(stat_at_trig), .stat_level(stat_level),
      .ev_rx_last_byte(ev_rx_last_byte), .ev_rx_overrun(ev_rx_overrun),
      .ev_tx_underrun(ev_tx_underrun), .ev_tx_done(ev_tx_done),
      .ev_stat_err_wr(ev_stat_err_wr), .ev_rx_eof(ev_rx_eof), .ev_cir_rx_stop(ev_cir_rx_stop),
      .acc_rhr_rd(acc_rhr_rd), .acc_iir_rd(acc_iir_rd), .acc_resume_rd(acc_resume_rd),
      .acc_stat_rd(acc_stat_rd), .iir_value(iir_value), .irq_out(irq_out),
      .tx_underrun_flag(tx_underrun_flag)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      tick();
      rst_n = 1'b1;
      tick();
   endtask

   initial begin
      #(8 * 100000);
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      @(negedge clk);
      tick();
      // R12 reset state
      chk("R12 word", iir_value, 8'h00);
      chk("R12 irq", {7'd0, irq_out}, 8'h00);
      chk("R12 undr", {7'd0, tx_underrun_flag}, 8'h00);
      rst_n = 1'b1;
      tick();

      // R1 R2 sweep of level inputs
      for (int i = 0; i < 32; i++) begin
         logic [1:0] e;
         {fifo_en, rx_data_ready, rx_above_trig, tx_hold_empty, tx_below_trig} = 5'(i);
         #1;
         e[0] = fifo_en ? rx_above_trig : rx_data_ready;
         e[1] = fifo_en ? tx_below_trig : tx_hold_empty;
         chk("R1 R2 levels", {6'd0, iir_value[1:0]}, {6'd0, e});
      end
      {fifo_en, rx_data_ready, rx_above_trig, tx_hold_empty, tx_below_trig} = 5'd0;

      // R5
      stat_at_trig = 1; #1;
      chk("R5 irda", iir_value, 8'h10);
      cir_mode = 1; #1;
      chk("R9 bit4 cir", iir_value, 8'h00);
      cir_mode = 0; stat_at_trig = 0; tick();

      // R3
      ev_rx_last_byte = 1; tick(); ev_rx_last_byte = 0;
      chk("R3 set", iir_value, 8'h04);
      acc_iir_rd = 1; tick(); acc_iir_rd = 0;
      chk("R3 iir read keeps", iir_value, 8'h04);
      acc_rhr_rd = 1; tick(); acc_rhr_rd = 0;
      chk("R3 rhr read clears", iir_value, 8'h00);

      // R4
      ev_rx_overrun = 1; tick(); ev_rx_overrun = 0;
      chk("R4 set", iir_value, 8'h08);
      acc_iir_rd = 1; acc_rhr_rd = 1; acc_stat_rd = 1; tick();
      acc_iir_rd = 0; acc_rhr_rd = 0; acc_stat_rd = 0;
      chk("R4 other reads keep", iir_value, 8'h08);
      acc_resume_rd = 1; tick(); acc_resume_rd = 0;
      chk("R4 resume clears", iir_value, 8'h00);

      // R6 underrun path
      ev_tx_underrun = 1; tick(); ev_tx_underrun = 0;
      chk("R6 underrun bit5", iir_value, 8'h20);
      chk("R6 underrun flag", {7'd0, tx_underrun_flag}, 8'h01);
      acc_iir_rd = 1; tick(); acc_iir_rd = 0;
      chk("R6 iir read keeps underrun", iir_value, 8'h20);
      acc_resume_rd = 1; tick(); acc_resume_rd = 0;
      chk("R6 resume clears", {iir_value[7:1], tx_underrun_flag}, 8'h00);
      // R6 completion path, R10 read sees value
      ev_tx_done = 1; tick(); ev_tx_done = 0;
      chk("R6 done bit5", iir_value, 8'h20);
      chk("R6 done no flag", {7'd0, tx_underrun_flag}, 8'h00);
      acc_iir_rd = 1; #1;
      chk("R10 read sees bit", iir_value, 8'h20);
      tick(); acc_iir_rd = 0;
      chk("R6 iir read clears done", iir_value, 8'h00);
      // both sources
      ev_tx_done = 1; ev_tx_underrun = 1; tick(); ev_tx_done = 0; ev_tx_underrun = 0;
      acc_iir_rd = 1; tick(); acc_iir_rd = 0;
      chk("R6 underrun remains", iir_value, 8'h20);
      acc_resume_rd = 1; tick(); acc_resume_rd = 0;
      chk("R6 both cleared", iir_value, 8'h00);

      // R7
      ev_stat_err_wr = 1; tick(); ev_stat_err_wr = 0;
      chk("R7 set", iir_value, 8'h40);
      stat_level = 4'd3; acc_stat_rd = 1; tick(); acc_stat_rd = 0;
      chk("R7 partial read keeps", iir_value, 8'h40);
      stat_level = 4'd1; tick();
      chk("R7 no read keeps", iir_value, 8'h40);
      acc_stat_rd = 1; tick(); acc_stat_rd = 0; stat_level = 0;
      chk("R7 draining read clears", iir_value, 8'h00);

      // R8
      ev_rx_eof = 1; tick(); ev_rx_eof = 0;
      chk("R8 set", iir_value, 8'h80);
      acc_rhr_rd = 1; tick(); acc_rhr_rd = 0;
      chk("R8 rhr read keeps", iir_value, 8'h80);
      acc_iir_rd = 1; tick(); acc_iir_rd = 0;
      chk("R8 iir read clears", iir_value, 8'h00);

      // R10 set wins
      ev_rx_eof = 1; acc_iir_rd = 1; tick(); ev_rx_eof = 0; acc_iir_rd = 0;
      chk("R10 eof wins", iir_value, 8'h80);
      ev_rx_overrun = 1; acc_resume_rd = 1; tick(); ev_rx_overrun = 0; acc_resume_rd = 0;
      chk("R10 overrun wins", iir_value, 8'h88);
      do_reset();

      // R9 CIR mode
      cir_mode = 1;
      ev_rx_last_byte = 1; tick(); ev_rx_last_byte = 0;
      chk("R9 last byte ignored", iir_value, 8'h00);
      ev_cir_rx_stop = 1; tick(); ev_cir_rx_stop = 0;
      chk("R9 rx stop set", iir_value, 8'h04);
      acc_rhr_rd = 1; tick(); acc_rhr_rd = 0;
      chk("R9 rhr keeps", iir_value, 8'h04);
      acc_iir_rd = 1; tick(); acc_iir_rd = 0;
      chk("R9 iir clears stop", iir_value, 8'h00);
      ev_tx_underrun = 1; tick(); ev_tx_underrun = 0;
      chk("R9 underrun ignored", {iir_value[7:1], tx_underrun_flag}, 8'h00);
      ev_tx_done = 1; tick(); ev_tx_done = 0;
      chk("R9 tx done set", iir_value, 8'h20);
      acc_iir_rd = 1; tick(); acc_iir_rd = 0;
      chk("R9 iir clears done", iir_value, 8'h00);
      ev_rx_eof = 1; ev_stat_err_wr = 1; stat_at_trig = 1; tick();
      ev_rx_eof = 0; ev_stat_err_wr = 0;
      chk("R9 bits 4 6 7 zero", iir_value, 8'h00);
      stat_at_trig = 0; cir_mode = 0; #1;
      chk("R9 cir events left no flag", iir_value, 8'h00);

      // R11 mask sweep
      rx_data_ready = 1;
      ev_rx_overrun = 1; ev_rx_last_byte = 1; ev_tx_done = 1; ev_rx_eof = 1; tick();
      ev_rx_overrun = 0; ev_rx_last_byte = 0; ev_tx_done = 0; ev_rx_eof = 0;
      for (int m = 0; m < 256; m++) begin
         logic [7:0] e;
         irq_mask = 8'(m);
         #1;
         e = 8'(m) & 8'hAD;
         chk("R11 masked word", iir_value, e);
         chk("R11 irq", {7'd0, irq_out}, {7'd0, |e});
      end
      irq_mask = 8'hFF;

      // R12 mid-run reset
      rx_data_ready = 0;
      rst_n = 1'b0; #1;
      chk("R12 async reset", iir_value, 8'h00);
      tick(); rst_n = 1'b1; tick();
      chk("R12 after reset", iir_value, 8'h00);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule